// File: doc/BRIEF.md
# Interrupt Controller Host Register Sequencer

This block is the register front end that a host processor sees for one eight-input interrupt controller. It has two byte-wide locations, chosen by a single address bit: a command location and a data location. The host programs the controller by writing a short chain of initialisation bytes. The block follows that chain and keeps the vector base byte and the interrupt mask. After the chain is complete, it sorts further command bytes into end-of-interrupt style commands (OCW2) and read-select commands (OCW3).

The block does not resolve priority and does not track which interrupts are in service. A companion block does that work. It drives the pending-request and in-service bytes into this block so the host can read them back, and it takes the OCW2 strobe and byte from this block. The host bus is synchronous. A read returns its byte one clock after the read enable. The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `pic_host_regs`

## Requirements
- R1: After reset, `vec_base`, `irq_mask` and `ocw2_byte` are 0x00, `ocw2_stb` and `seq_err` are low, and the read selection is the request byte, so `stat_isr_sel` is low.
- R2: A command write (`port_sel`=0) with bit 4 set is an initialisation start in every state. Its bit 1 means single controller and its bit 0 means a mode byte follows. It moves the sequencer to wait for the vector byte. A start written in the middle of a chain restarts the chain.
- R3: A data write (`port_sel`=1) while the sequencer waits for the vector byte loads `vec_base`. If the start byte had bit 1 clear, the next data byte is a cascade byte.
- R4: After the vector byte, if the start byte had bit 1 set, the sequencer waits for a mode byte when bit 0 was set, and goes straight to ready when bit 0 was clear.
- R5: After the cascade byte, the sequencer waits for a mode byte when start bit 0 was set, and goes to ready otherwise. The data write that follows a mode byte always finds the sequencer ready.
- R6: A data write loads `irq_mask` only when the sequencer is ready or idle before any start byte. Vector, cascade and mode bytes leave the mask unchanged. A data-location read returns the mask.
- R7: When the sequencer is ready, a command write with bits 4:3 = 00 is OCW2. On the next clock `ocw2_stb` is high for exactly one cycle, and `ocw2_byte` holds the written byte until the next OCW2.
- R8: When the sequencer is ready, a command write with bits 4:3 = 01 is OCW3, and its bits 1:0 set the read selection. After that, a command-location read returns `req_bits` for 10, returns `isr_bits` for 11, and returns 0x00 for 00 or 01. `stat_isr_sel` is high exactly when the selection is 11.
- R9: A command write without bit 4 while the sequencer is not ready changes no state and produces a one-cycle `seq_err` pulse on the next clock. It produces no `ocw2_stb`.
- R10: `rd_data` takes the selected byte on the clock edge where `rd_en` is high, using the register values from before any write in that same cycle. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Location select: 0 command, 1 data |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| req_bits | input | 8 | Pending request byte from the companion block |
| isr_bits | input | 8 | In-service byte from the companion block |
| vec_base | output | 8 | Stored vector base byte |
| irq_mask | output | 8 | Interrupt mask |
| ocw2_stb | output | 1 | One-cycle pulse after an OCW2 write |
| ocw2_byte | output | 8 | Last OCW2 byte |
| stat_isr_sel | output | 1 | High when command reads return the in-service byte |
| seq_err | output | 1 | One-cycle pulse after a rejected command write |

## Verification
The sequencer state is not visible at the ports. The hardest case to show is where the chain actually ends for each combination of the single-controller and mode-follows bits. The stimulus programs every combination of those two bits. After each chain it writes extra data bytes, and the point where the mask starts to change shows where the sequencer became ready. Command probes without bit 4 inside the chain show the non-ready state through `seq_err`. The chain is also restarted in the middle to check that a start byte takes priority. A reference model in the bench follows every clock, including random traffic.

// File: rtl/pic_host_pkg.sv
package pic_host_pkg;
  localparam int BYTE_W   = 8;
  localparam int INIT_BIT = 4;   // set on a command write: start of the chain
  localparam int KIND_BIT = 3;   // with INIT_BIT clear: 0 -> OCW2, 1 -> OCW3
  localparam int SNGL_BIT = 1;   // start byte: single controller, no cascade byte
  localparam int MODE_BIT = 0;   // start byte: a mode byte follows
  localparam logic [1:0] SEL_REQ = 2'b10;
  localparam logic [1:0] SEL_ISR = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } seq_st_t;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/pic_cmd_classify.sv
module pic_cmd_classify (
  input  logic       wr_en,
  input  logic       port_sel,
  input  logic [1:0] kind,
  input  logic       run,
  output logic       init_wr,
  output logic       data_wr,
  output logic       ocw2_wr,
  output logic       ocw3_wr,
  output logic       bad_wr
);
  logic cmd_wr;

  always_comb begin
    cmd_wr  = wr_en & ~port_sel;
    data_wr = wr_en & port_sel;
    init_wr = cmd_wr & kind[1];
    ocw2_wr = cmd_wr & ~kind[1] & run & ~kind[0];
    ocw3_wr = cmd_wr & ~kind[1] & run & kind[0];
    bad_wr  = cmd_wr & ~kind[1] & ~run;
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_host_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          init_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output seq_st_t       state,
  output logic [DW-1:0] vec_base
);
  seq_st_t       st_q, st_d;
  logic [DW-1:0] base_q, base_d;
  logic          casc_q, casc_d;
  logic          mode_q, mode_d;
  logic          seq_en;

  assign seq_en = init_wr | data_wr;

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    casc_d = casc_q;
    mode_d = mode_q;
    if (init_wr) begin
      st_d   = ST_VEC;
      casc_d = ~wdata[SNGL_BIT];
      mode_d = wdata[MODE_BIT];
    end else if (data_wr) begin
      unique case (st_q)
        ST_VEC: begin
          base_d = wdata;
          if (casc_q)      st_d = ST_CASC;
          else if (mode_q) st_d = ST_MODE;
          else             st_d = ST_RUN;
        end
        ST_CASC: st_d = mode_q ? ST_MODE : ST_RUN;
        ST_MODE: st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      casc_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (seq_en) begin
      st_q   <= st_d;
      base_q <= base_d;
      casc_q <= casc_d;
      mode_q <= mode_d;
    end
  end

  assign state    = st_q;
  assign vec_base = base_q;
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port
  import pic_host_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          rd_en,
  input  logic          port_sel,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isr_bits,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_q, rd_d;

  always_comb begin
    if (port_sel)            rd_d = mask;
    else if (sel == SEL_REQ) rd_d = req_bits;
    else if (sel == SEL_ISR) rd_d = isr_bits;
    else                     rd_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pic_host_regs.sv
module pic_host_regs
  import pic_host_pkg::*;
#(
  parameter int DW        = BYTE_W,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isr_bits,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] irq_mask,
  output logic          ocw2_stb,
  output logic [DW-1:0] ocw2_byte,
  output logic          stat_isr_sel,
  output logic          seq_err
);
  logic          rst_i_n;
  seq_st_t       state;
  logic          run, init_wr, data_wr, ocw2_wr, ocw3_wr, bad_wr;
  logic          mask_en;
  logic [DW-1:0] mask_q, ocw2_q;
  logic [1:0]    sel_q;
  logic          stb_q, err_q;

  pic_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_sync_no(rst_i_n)
  );

  assign run = (state == ST_RUN);

  pic_cmd_classify u_cls (
    .wr_en(wr_en), .port_sel(port_sel), .kind(wr_data[INIT_BIT:KIND_BIT]),
    .run(run), .init_wr(init_wr), .data_wr(data_wr), .ocw2_wr(ocw2_wr),
    .ocw3_wr(ocw3_wr), .bad_wr(bad_wr)
  );

  pic_init_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_ni(rst_i_n), .init_wr(init_wr), .data_wr(data_wr),
    .wdata(wr_data), .state(state), .vec_base(vec_base)
  );

  assign mask_en = data_wr & (run | (state == ST_IDLE));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mask_q <= '0;
      ocw2_q <= '0;
      sel_q  <= SEL_REQ;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= wr_data;
      if (ocw2_wr) ocw2_q <= wr_data;
      if (ocw3_wr) sel_q  <= wr_data[1:0];
      stb_q <= ocw2_wr;
      err_q <= bad_wr;
    end
  end

  pic_rd_port #(.DW(DW)) u_rd (
    .clk(clk), .rst_ni(rst_i_n), .rd_en(rd_en), .port_sel(port_sel),
    .sel(sel_q), .req_bits(req_bits), .isr_bits(isr_bits), .mask(mask_q),
    .rd_data(rd_data)
  );

  assign irq_mask     = mask_q;
  assign ocw2_byte    = ocw2_q;
  assign ocw2_stb     = stb_q;
  assign seq_err      = err_q;
  assign stat_isr_sel = (sel_q == SEL_ISR);
endmodule

// File: rtl/pic_host_regs_chk.sv
module pic_host_regs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_sel,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] vec_base,
  input logic [DW-1:0] irq_mask,
  input logic          ocw2_stb,
  input logic [DW-1:0] ocw2_byte,
  input logic          stat_isr_sel,
  input logic          seq_err
);
  // R7
  ocw2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocw2_stb |-> ($past(wr_en) && !$past(port_sel) && ocw2_byte == $past(wr_data)));
  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> ($past(wr_en) && !$past(port_sel) && !$past(wr_data[4])));
  // R9
  err_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_err && ocw2_stb));
  // R6
  mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_mask) |-> ($past(wr_en) && $past(port_sel) && irq_mask == $past(wr_data)));
  // R3
  base_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_base) |-> ($past(wr_en) && $past(port_sel)));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(rd_en));
  // R8
  sel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_isr_sel) |-> ($past(wr_en) && !$past(port_sel)));
endmodule

bind pic_host_regs pic_host_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .vec_base(vec_base),
  .irq_mask(irq_mask), .ocw2_stb(ocw2_stb), .ocw2_byte(ocw2_byte),
  .stat_isr_sel(stat_isr_sel), .seq_err(seq_err)
);

// File: tb/pic_host_regs_test.sv
`timescale 1ns/1ps
module pic_host_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00, req_bits = 8'h00, isr_bits = 8'h00;
  logic [7:0] rd_data, vec_base, irq_mask, ocw2_byte;
  logic       ocw2_stb, stat_isr_sel, seq_err;

  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  pic_host_regs uut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .req_bits(req_bits),
    .isr_bits(isr_bits), .vec_base(vec_base), .irq_mask(irq_mask),
    .ocw2_stb(ocw2_stb), .ocw2_byte(ocw2_byte), .stat_isr_sel(stat_isr_sel),
    .seq_err(seq_err)
  );

  // Reference model: 0 idle, 1 vector, 2 cascade, 3 mode, 4 ready
  int   m_st;
  bit   m_casc, m_mode, m_stb, m_err;
  logic [7:0] m_base, m_mask, m_ocw2, m_rd;
  logic [1:0] m_sel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_casc = 0; m_mode = 0; m_stb = 0; m_err = 0;
      m_base = 0; m_mask = 0; m_ocw2 = 0; m_rd = 0; m_sel = 2'b10;
    end else begin
      if (rd_en) begin
        if (port_sel)          m_rd = m_mask;
        else if (m_sel == 2'b10) m_rd = req_bits;
        else if (m_sel == 2'b11) m_rd = isr_bits;
        else                   m_rd = 8'h00;
      end
      m_stb = 0; m_err = 0;
      if (wr_en && !port_sel) begin
        if (wr_data[4]) begin
          m_st = 1; m_casc = !wr_data[1]; m_mode = wr_data[0];
        end else if (m_st == 4) begin
          if (!wr_data[3]) begin m_ocw2 = wr_data; m_stb = 1; end
          else m_sel = wr_data[1:0];
        end else m_err = 1;
      end else if (wr_en) begin
        case (m_st)
          1: begin m_base = wr_data; m_st = m_casc ? 2 : (m_mode ? 3 : 4); end
          2: m_st = m_mode ? 3 : 4;
          3: m_st = 4;
          default: m_mask = wr_data;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %02h expected %02h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("vec_base", vec_base, m_base);
    chk("irq_mask", irq_mask, m_mask);
    chk("ocw2_stb", {7'd0, ocw2_stb}, {7'd0, m_stb});
    chk("ocw2_byte", ocw2_byte, m_ocw2);
    chk("seq_err", {7'd0, seq_err}, {7'd0, m_err});
    chk("rd_data", rd_data, m_rd);
    chk("stat_isr_sel", {7'd0, stat_isr_sel}, {7'd0, m_sel == 2'b11});
  end

  task automatic idle();
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask
  task automatic wr(bit p, logic [7:0] d);
    @(negedge clk); port_sel = p; wr_en = 1; rd_en = 0; wr_data = d;
  endtask
  task automatic rd(bit p);
    @(negedge clk); port_sel = p; wr_en = 0; rd_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    req_bits = 8'hA5; isr_bits = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: explicit reset values
    chk("R1 vec_base", vec_base, 8'h00);
    chk("R1 irq_mask", irq_mask, 8'h00);
    chk("R1 ocw2_byte", ocw2_byte, 8'h00);
    chk("R1 flags", {5'd0, ocw2_stb, seq_err, stat_isr_sel}, 8'h00);
    cmp_on = 1'b1;
    rd(0); idle();                               // R1: default selects request byte
    chk("R1 rd_req", rd_data, 8'hA5);

    phase = "R6";
    wr(1, 8'h3C); rd(1); idle(); idle();         // R6: idle accepts mask
    phase = "R9";
    wr(0, 8'h0A); idle(); idle();                // R9: rejected in idle
    chk("R9 sel unchanged", {7'd0, stat_isr_sel}, 8'h00);

    phase = "R3";                                // cascade, no mode byte
    wr(0, 8'h10); wr(1, 8'h20); wr(0, 8'h00); wr(1, 8'h55); wr(1, 8'h0F); idle();
    chk("R3 vec", vec_base, 8'h20);
    chk("R3 mask", irq_mask, 8'h0F);

    phase = "R5";                                // cascade plus mode byte
    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(0, 8'h08); wr(1, 8'h01);
    wr(1, 8'hF0); idle();
    chk("R5 mask", irq_mask, 8'hF0);

    phase = "R4";                                // single, mode byte
    wr(0, 8'h13); wr(1, 8'h68); wr(1, 8'h01); wr(1, 8'h81); idle();
    chk("R4 mode", irq_mask, 8'h81);
    wr(0, 8'h12); wr(1, 8'h70); wr(1, 8'h42); idle();   // single, no mode byte
    chk("R4 direct", irq_mask, 8'h42);
    chk("R4 vec", vec_base, 8'h70);

    phase = "R2";                                // restart mid chain
    wr(0, 8'h11); wr(1, 8'h18); wr(0, 8'h12); wr(1, 8'h28); wr(1, 8'h99); idle();
    chk("R2 vec", vec_base, 8'h28);
    chk("R2 mask", irq_mask, 8'h99);
    wr(0, 8'h1F); idle();                         // start from ready
    wr(1, 8'hC8); wr(1, 8'h01); wr(1, 8'h07); idle();

    phase = "R7";
    wr(0, 8'h20); wr(0, 8'h64); idle(); idle();
    chk("R7 byte", ocw2_byte, 8'h64);

    phase = "R8";
    wr(0, 8'h0B); rd(0); idle();
    chk("R8 isr", rd_data, 8'h3C);
    wr(0, 8'h08); rd(0); idle();
    chk("R8 zero", rd_data, 8'h00);
    wr(0, 8'h0A); rd(0); idle();
    chk("R8 req", rd_data, 8'hA5);

    phase = "R10";
    wr(1, 8'h5A); rd(1);
    @(negedge clk); port_sel = 1; wr_en = 1; rd_en = 1; wr_data = 8'h77;
    idle(); req_bits = 8'h11; idle(); idle();
    chk("R10 old mask", rd_data, 8'h5A);

    phase = "R6 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      port_sel = 1'($urandom);
      wr_en    = ($urandom % 3) == 0;
      rd_en    = ($urandom % 3) == 0;
      wr_data  = 8'($urandom);
      if (($urandom % 5) == 0) wr_data[4] = 1'b0;
      req_bits = 8'($urandom);
      isr_bits = 8'($urandom);
    end
    idle(); idle();
    cmp_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule